// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block conditions a bank of external interrupt lines and steers each one to a single core. Every source is programmed with three bits: a sense inversion, a choice between level and edge detection, and a dual-edge option that makes any transition count. Edge sources keep their event in a per-source latch until it is acknowledged. Level sources are never latched: their pending state follows the input after sense inversion.

Software reaches the block over a flat 32-bit word-addressed register bus with combinational read data. Masks are never written directly. One register sets mask bits and another clears them, and a third reports the result. A single command register either injects an edge event on a chosen source, acting as a software interrupt, or acknowledges it.

Each source has a route register that names one core. Every core output is the OR of the sources that are pending, unmasked and routed to that core, and it is registered.

Top module: `shintc_top`

## Requirements
- R1: After reset every source reads non-inverted (polarity bank word 0x008 = 0), level mode (trigger bank 0x010 = 0), dual-edge off (0x018 = 0), masked (mask word 0x020 = 0), routed to core 0 (route register 0x100+n = 0), and all core outputs are low.
- R2: Word 0x000 is read-only configuration: bits [7:0] hold NUM_SRC/8-1 and bits [15:8] hold NUM_CORE-1, which gives 0x0303 for the default 32 sources and 4 cores.
- R3: A write to 0x028 sets the mask bits where the data has 1s, and a write to 0x030 clears them. A zero bit in either write leaves its mask bit unchanged, and no other register changes the mask. Word w of each bank sits at the bank base + w, and source n is bit n%32.
- R4: In level mode (trigger bit 0) the pending bit, read at 0x038, equals the synchronized input XOR the polarity bit (1 = active low).
- R5: In edge mode (trigger bit 1) with dual-edge off, a transition of the input into its active level sets the source's latch. The latch stays set after the input returns.
- R6: In edge mode with the dual-edge bit set, both rising and falling input transitions set the latch, whatever the polarity bit holds.
- R7: A write to 0x040 carries the source number in bits [7:0]. Bit 31 = 1 sets that source's latch and bit 31 = 0 clears it. For a level-mode source the write has no effect.
- R8: The route register at 0x100+n holds a core index in bits [1:0]. Core c's output is high when at least one source is pending, unmasked and routed to c.
- R9: A level input change reaches the core output on the third rising clock edge after it is applied, and an edge-mode event reaches it on the fourth.
- R10: Switching an edge source to level mode drops its latch, so its pending bit then follows the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | NUM_SRC | Asynchronous external interrupt lines |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 9 | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| coreIrq | output | NUM_CORE | One interrupt request per core |

## Verification
Most state faults appear on the pending word within the same access: a lost or stuck latch, a swapped sense bit, or a dual-edge bit that does not take effect. A wrong route or mask shows on the wrong core output one cycle after pending settles. Latency faults, such as a missing synchronizer stage or an unregistered output, move the first high cycle of a core output earlier or later than the third or fourth edge. Random mixes of writes and input toggles are compared after every step, so a divergence is seen within one step.

// File: rtl/shintc_pkg.sv
package shintc_pkg;
  // word offsets of the per-source banks (bank index = addr[5:3])
  localparam int BANK_POL   = 1;
  localparam int BANK_TRIG  = 2;
  localparam int BANK_DUAL  = 3;
  localparam int BANK_MASK  = 4;
  localparam int BANK_MSET  = 5;
  localparam int BANK_MCLR  = 6;
  localparam int BANK_PEND  = 7;
  localparam int WEDGE_ADDR = 'h040;

  typedef struct packed {
    logic       polWr;
    logic       trigWr;
    logic       dualWr;
    logic       maskSet;
    logic       maskClr;
    logic       wedgeWr;
    logic       routeWr;
    logic [2:0] wordIdx;
    logic [7:0] srcIdx;
  } strobe_t;
endpackage

// File: rtl/shintc_ctl.sv
module shintc_ctl
  import shintc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int CORE_W   = 2
) (
  input  logic                       busWrEn,
  input  logic [8:0]                 busAddr,
  input  logic [NUM_SRC-1:0]         polQ,
  input  logic [NUM_SRC-1:0]         trigQ,
  input  logic [NUM_SRC-1:0]         dualQ,
  input  logic [NUM_SRC-1:0]         maskQ,
  input  logic [NUM_SRC-1:0]         pendVec,
  input  logic [NUM_SRC*CORE_W-1:0]  routeFlat,
  output strobe_t                    strb,
  output logic [31:0]                busRdData
);
  localparam int NWORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W  = NWORDS * 32;

  logic       isBank;
  logic       isRoute;
  logic [2:0] bankSel;
  logic [PAD_W-1:0] padPol, padTrig, padDual, padMask, padPend;

  assign isBank  = (busAddr[8:6] == 3'd0);
  assign isRoute = busAddr[8];
  assign bankSel = busAddr[5:3];

  assign padPol  = PAD_W'(polQ);
  assign padTrig = PAD_W'(trigQ);
  assign padDual = PAD_W'(dualQ);
  assign padMask = PAD_W'(maskQ);
  assign padPend = PAD_W'(pendVec);

  always_comb begin
    strb         = '0;
    strb.wordIdx = busAddr[2:0];
    strb.srcIdx  = busAddr[7:0];
    strb.polWr   = busWrEn && isBank && bankSel == 3'(BANK_POL);
    strb.trigWr  = busWrEn && isBank && bankSel == 3'(BANK_TRIG);
    strb.dualWr  = busWrEn && isBank && bankSel == 3'(BANK_DUAL);
    strb.maskSet = busWrEn && isBank && bankSel == 3'(BANK_MSET);
    strb.maskClr = busWrEn && isBank && bankSel == 3'(BANK_MCLR);
    strb.wedgeWr = busWrEn && busAddr == 9'(WEDGE_ADDR);
    strb.routeWr = busWrEn && isRoute;
  end

  always_comb begin
    int w;
    w = int'(busAddr[2:0]);
    busRdData = '0;
    if (busAddr == 9'd0) begin
      busRdData = {16'd0, 8'(NUM_CORE - 1), 8'(NUM_SRC / 8 - 1)};
    end else if (isBank && w < NWORDS) begin
      case (int'(bankSel))
        BANK_POL:  busRdData = padPol[w*32 +: 32];
        BANK_TRIG: busRdData = padTrig[w*32 +: 32];
        BANK_DUAL: busRdData = padDual[w*32 +: 32];
        BANK_MASK: busRdData = padMask[w*32 +: 32];
        BANK_PEND: busRdData = padPend[w*32 +: 32];
        default:   busRdData = '0;
      endcase
    end else if (isRoute && int'(busAddr[7:0]) < NUM_SRC) begin
      busRdData = 32'(routeFlat[int'(busAddr[7:0])*CORE_W +: CORE_W]);
    end
  end
endmodule

// File: rtl/shintc_dp.sv
module shintc_dp
  import shintc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4,
  parameter int CORE_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcIn,
  input  strobe_t                   strb,
  input  logic [31:0]               wrData,
  output logic [NUM_SRC-1:0]        polQ,
  output logic [NUM_SRC-1:0]        trigQ,
  output logic [NUM_SRC-1:0]        dualQ,
  output logic [NUM_SRC-1:0]        maskQ,
  output logic [NUM_SRC-1:0]        latchQ,
  output logic [NUM_SRC-1:0]        pendVec,
  output logic [NUM_SRC*CORE_W-1:0] routeFlat,
  output logic [NUM_CORE-1:0]       coreIrq
);
  logic [NUM_SRC-1:0] syncA, syncB, syncPrev;
  logic [NUM_SRC-1:0] polN, trigN, dualN, maskN, latchN;
  logic [NUM_SRC-1:0] activeNow, activeOld, evt, wedgeHit, wSet, wClr;
  logic [CORE_W-1:0]  routeQ [NUM_SRC];
  logic [NUM_CORE-1:0] irqN;

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= srcIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign activeNow = syncB ^ polQ;
  assign activeOld = syncPrev ^ polQ;
  assign evt       = (dualQ & (syncB ^ syncPrev)) | (~dualQ & activeNow & ~activeOld);

  always_comb begin
    polN  = polQ;
    trigN = trigQ;
    dualN = dualQ;
    maskN = maskQ;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.wordIdx == 3'(i / 32)) begin
        if (strb.polWr)   polN[i]  = wrData[i % 32];
        if (strb.trigWr)  trigN[i] = wrData[i % 32];
        if (strb.dualWr)  dualN[i] = wrData[i % 32];
        if (strb.maskSet && wrData[i % 32]) maskN[i] = 1'b1;
        if (strb.maskClr && wrData[i % 32]) maskN[i] = 1'b0;
      end
      wedgeHit[i] = strb.wedgeWr && wrData[7:0] == 8'(i);
    end
  end

  assign wSet   = wedgeHit & {NUM_SRC{wrData[31]}};
  assign wClr   = wedgeHit & {NUM_SRC{~wrData[31]}};
  // a hardware event in the same cycle as an acknowledge is kept
  assign latchN = trigQ & ((latchQ & ~wClr) | wSet | evt);

  assign pendVec = (trigQ & latchQ) | (~trigQ & activeNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ   <= '0;
      trigQ  <= '0;
      dualQ  <= '0;
      maskQ  <= '0;
      latchQ <= '0;
    end else begin
      polQ   <= polN;
      trigQ  <= trigN;
      dualQ  <= dualN;
      maskQ  <= maskN;
      latchQ <= latchN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) routeQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (strb.routeWr && strb.srcIdx == 8'(i)) routeQ[i] <= wrData[CORE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gRoute
    assign routeFlat[g*CORE_W +: CORE_W] = routeQ[g];
  end

  always_comb begin
    irqN = '0;
    for (int c = 0; c < NUM_CORE; c++)
      for (int i = 0; i < NUM_SRC; i++)
        if (pendVec[i] && maskQ[i] && routeQ[i] == CORE_W'(c)) irqN[c] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coreIrq <= '0;
    else       coreIrq <= irqN;
  end
endmodule

// File: rtl/shintc_top.sv
module shintc_top
  import shintc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic                busWrEn,
  input  logic [8:0]          busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic [NUM_CORE-1:0] coreIrq
);
  localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

  strobe_t strb;
  logic [NUM_SRC-1:0] polQ, trigQ, dualQ, maskQ, latchQ, pendVec;
  logic [NUM_SRC*CORE_W-1:0] routeFlat;

  shintc_ctl #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .CORE_W(CORE_W)) uCtl (
    .busWrEn(busWrEn), .busAddr(busAddr),
    .polQ(polQ), .trigQ(trigQ), .dualQ(dualQ), .maskQ(maskQ), .pendVec(pendVec),
    .routeFlat(routeFlat), .strb(strb), .busRdData(busRdData)
  );

  shintc_dp #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .CORE_W(CORE_W)) uDp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strb(strb), .wrData(busWrData),
    .polQ(polQ), .trigQ(trigQ), .dualQ(dualQ), .maskQ(maskQ), .latchQ(latchQ),
    .pendVec(pendVec), .routeFlat(routeFlat), .coreIrq(coreIrq)
  );
endmodule

// File: rtl/shintc_chk.sv
module shintc_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CORE = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic [NUM_SRC-1:0]  trigQ,
  input logic [NUM_SRC-1:0]  latchQ,
  input logic [NUM_SRC-1:0]  maskQ,
  input logic [NUM_CORE-1:0] coreIrq
);
  assert_level_nolatch_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchQ & ~$past(trigQ)) == '0));

  assert_mask_by_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ != $past(maskQ)) |-> $past(busWrEn));

  assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|coreIrq) |-> $past(|maskQ));

  assert_latch_edge_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchQ & ~$past(latchQ) & ~$past(trigQ)) == '0));

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (coreIrq == '0));
endmodule

bind shintc_top shintc_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .trigQ(trigQ),
  .latchQ(latchQ), .maskQ(maskQ), .coreIrq(coreIrq)
);

// File: tb/sim_shintc_top.sv
module sim_shintc_top;
  localparam int NS = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] srcIn = '0;
  logic busWrEn = 1'b0;
  logic [8:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NC-1:0] coreIrq;

  always #5 clk = ~clk;

  shintc_top #(.NUM_SRC(NS), .NUM_CORE(NC)) u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .coreIrq(coreIrq)
  );

  int nChk = 0;
  int nBad = 0;

  // reference state built from the requirements
  logic [NS-1:0] mPol = '0, mTrig = '0, mDual = '0, mMask = '0, mLatch = '0, mIn = '0;
  int mRoute [NS];

  function automatic logic [NS-1:0] expPend();
    return (mTrig & mLatch) | (~mTrig & (mIn ^ mPol));
  endfunction

  function automatic logic [NC-1:0] expIrq();
    logic [NC-1:0] r = '0;
    logic [NS-1:0] p = expPend() & mMask;
    for (int i = 0; i < NS; i++) if (p[i]) r[mRoute[i]] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    int s;
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    case (a)
      9'h008: mPol = d;
      9'h010: begin mTrig = d; mLatch &= mTrig; end
      9'h018: mDual = d;
      9'h028: mMask |= d;
      9'h030: mMask &= ~d;
      9'h040: begin s = int'(d[7:0]); if (s < NS && mTrig[s]) mLatch[s] = d[31]; end
      default: if (a[8] && int'(a[7:0]) < NS) mRoute[int'(a[7:0])] = int'(d[1:0]);
    endcase
  endtask

  task automatic drive(input logic [NS-1:0] nv);
    logic [NS-1:0] evt;
    @(negedge clk);
    evt = (mDual & (mIn ^ nv)) | (~mDual & ~(mIn ^ mPol) & (nv ^ mPol));
    mLatch |= mTrig & evt;
    mIn = nv;
    srcIn = nv;
  endtask

  task automatic settleCheck(input string req);
    logic [31:0] d;
    repeat (6) @(negedge clk);
    rd(9'h038, d); check({req, " pending"}, d, expPend());
    rd(9'h020, d); check({req, " mask"}, d, mMask);
    check({req, " coreIrq"}, 32'(coreIrq), 32'(expIrq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) mRoute[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(9'h008, d); check("R1 pol", d, 0);
    rd(9'h010, d); check("R1 trig", d, 0);
    rd(9'h018, d); check("R1 dual", d, 0);
    rd(9'h020, d); check("R1 mask", d, 0);
    rd(9'h105, d); check("R1 route", d, 0);
    check("R1 coreIrq", 32'(coreIrq), 0);
    // R2 configuration word
    rd(9'h000, d); check("R2 config", d, 32'h0000_0303);

    // R3 set/clear mask, zeros ignored
    wr(9'h028, 32'h0000_00F0); rd(9'h020, d); check("R3 set", d, 32'h0000_00F0);
    wr(9'h028, 32'h0); rd(9'h020, d); check("R3 set zero", d, 32'h0000_00F0);
    wr(9'h030, 32'h0000_0030); rd(9'h020, d); check("R3 clear", d, 32'h0000_00C0);
    wr(9'h030, 32'h0); rd(9'h020, d); check("R3 clear zero", d, 32'h0000_00C0);
    wr(9'h030, 32'hFFFF_FFFF);

    // R9 level latency: source 0, core 0
    wr(9'h028, 32'h1);
    @(negedge clk); srcIn[0] = 1'b1; mIn[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1 check("R9 level edge2", 32'(coreIrq[0]), 0);
    @(posedge clk); #1 check("R9 level edge3", 32'(coreIrq[0]), 1);
    settleCheck("R4 level high");
    drive(mIn & ~32'h1); settleCheck("R4 level drop");

    // R4 active-low source 1 routed to core 2
    wr(9'h101, 32'd2); wr(9'h008, 32'h2); wr(9'h028, 32'h2);
    settleCheck("R4 active low asserted");
    check("R8 core2", 32'(coreIrq), 32'h4);
    drive(mIn | 32'h2); settleCheck("R4 active low idle");

    // R5 + R9 edge latency: source 2 routed to core 1
    wr(9'h102, 32'd1); wr(9'h010, 32'h4); wr(9'h028, 32'h4);
    @(negedge clk); srcIn[2] = 1'b1; mIn[2] = 1'b1; mLatch[2] = 1'b1;
    repeat (3) @(posedge clk); #1 check("R9 edge edge3", 32'(coreIrq[1]), 0);
    @(posedge clk); #1 check("R9 edge edge4", 32'(coreIrq[1]), 1);
    drive(mIn & ~32'h4); settleCheck("R5 latch held");
    wr(9'h040, 32'h0000_0002); settleCheck("R7 acknowledge");

    // R6 dual edge on source 3 with polarity set
    wr(9'h008, mPol | 32'h8); wr(9'h010, mTrig | 32'h8); wr(9'h018, 32'h8); wr(9'h028, 32'h8);
    drive(mIn | 32'h8); settleCheck("R6 rise");
    wr(9'h040, 32'h0000_0003); settleCheck("R6 cleared");
    drive(mIn & ~32'h8); settleCheck("R6 fall");
    rd(9'h038, d); check("R6 fall latched", 32'(d[3]), 1);

    // R7 wedge on level source 4 ignored, on edge source 5 sets
    wr(9'h028, 32'h30);
    wr(9'h040, 32'h8000_0004); settleCheck("R7 level ignored");
    rd(9'h038, d); check("R7 level bit", 32'(d[4]), 0);
    wr(9'h010, mTrig | 32'h20);
    wr(9'h040, 32'h8000_0005); settleCheck("R7 software set");
    rd(9'h038, d); check("R7 set bit", 32'(d[5]), 1);

    // R10 back to level drops latch
    wr(9'h010, mTrig & ~32'h20); settleCheck("R10 level again");
    rd(9'h038, d); check("R10 bit", 32'(d[5]), 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 8));
      case (op)
        0: wr(9'h008, $urandom());
        1: wr(9'h010, $urandom());
        2: wr(9'h018, $urandom());
        3: wr(9'h028, $urandom());
        4: wr(9'h030, $urandom());
        5: wr(9'h040, {$urandom_range(0, 1) == 1, 23'd0, 8'($urandom_range(0, NS - 1))});
        6: wr(9'h100 + 9'($urandom_range(0, NS - 1)), 32'($urandom_range(0, NC - 1)));
        default: drive(mIn ^ NS'($urandom()));
      endcase
      settleCheck("R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule